// File: doc/BRIEF.md
# I2C Channel Selector with Interrupt Gathering

This block is the digital controller of a one-of-four bus multiplexer that a host programs over I2C. It watches the sampled SCL and SDA lines with a fast system clock, finds START and STOP conditions, receives the address byte and data bytes, and pulls SDA low through an open-drain output to acknowledge and to return read data. Bits 2:0 of each written byte form a channel selection. Bit 2 enables a channel and bits 1:0 give its index. A new selection is held back and reaches the one-hot enable vector only when the next STOP is seen.

Four active-low interrupt inputs, one for each downstream channel, are combined into one active-low output. An input counts whether or not its channel is selected. When the host reads the block, the upper nibble of the returned byte shows which inputs are low at that moment. The host can then select the channel that raised the interrupt and service the device on it.

Top module: `i2c_chansel`

## Requirements
- R1: After reset `chan_en` is 0000 and `sda_pull` is 0, so SDA is released.
- R2: The block answers the 7-bit address {ADDR_HI, addr_pins}, with ADDR_HI = 4'b1110 by default. The address byte is followed by a direction bit: 0 means write and 1 means read. On a match the block pulls SDA low during the acknowledge bit.
- R3: Every data byte of a write transfer is acknowledged. When several bytes arrive in one transfer, only the last one determines the selection.
- R4: A written selection leaves `chan_en` unchanged until the next STOP condition, and is applied at that STOP.
- R5: The selection decodes as follows. If bit 2 is 1, `chan_en` is one-hot with bit (bits 1:0) set. If bit 2 is 0, `chan_en` is 0000. At most one enable is ever high.
- R6: `irq_n_out` is the AND of the four `irq_n_in` bits. It goes low for any low input, whatever channel is selected, and returns high only when every input is high again.
- R7: A read returns one byte. Bits 7:4 are 1 where `irq_n_in[3:0]` is low, with bit 4 for channel 0 and bit 7 for channel 3. Bit 3 is 0. Bits 2:0 are the applied selection. The interrupt bits are captured at the start of each byte.
- R8: During a read, a master acknowledge starts another status byte. A master not-acknowledge makes the block release SDA until the next START or STOP.
- R9: A START received in the middle of a transfer or a byte restarts address reception. A selection that is written but not yet applied is discarded when a START arrives before its STOP.
- R10: A transfer to a different address gets no acknowledge, and its data bytes do not change the selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled I2C clock line |
| sda_in | input | 1 | Sampled I2C data line |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_pins | input | 3 | Low three bits of the slave address |
| irq_n_in | input | 4 | Active-low interrupt per channel |
| irq_n_out | output | 1 | Active-low combined interrupt |
| chan_en | output | 4 | One-hot channel enable |

## Verification
The combined interrupt output and the enable vector are driven by separate logic. They can change together when an interrupt input toggles in the same cycle that SDA rises for the STOP that applies a pending selection. The bench forces this case by changing an interrupt input in the same step in which it releases SDA for that STOP. It then checks the new one-hot enable and the lowered interrupt output. Next it reads the block and expects both the captured interrupt nibble and the newly applied selection in a single byte.

// File: rtl/i2c_chansel_pkg.sv
package i2c_chansel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_SKIP
  } xfer_st_e;

  // selection bits -> one-hot enable (bit 2 enables, bits 1:0 index)
  function automatic logic [3:0] sel_decode(input logic [2:0] sel);
    logic [3:0] en;
    en = 4'b0000;
    if (sel[2]) en[sel[1:0]] = 1'b1;
    return en;
  endfunction

  // read byte: active-high interrupt flags over the select bits
  function automatic logic [7:0] status_byte(input logic [3:0] irq_n,
                                             input logic [2:0] sel);
    return {~irq_n, 1'b0, sel};
  endfunction

  function automatic logic addr_match(input logic [6:0] rx,
                                      input logic [3:0] hi,
                                      input logic [2:0] pins);
    return rx == {hi, pins};
  endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_in};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_in};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_pipe[DEPTH-2];
  assign scl_old = scl_pipe[DEPTH-1];
  assign sda_now = sda_pipe[DEPTH-2];
  assign sda_old = sda_pipe[DEPTH-1];

  assign sda_lvl   = sda_now;
  assign start_evt = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_evt  = scl_now & scl_old & ~sda_old & sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
endmodule

// File: rtl/i2c_irq_gather.sv
module i2c_irq_gather #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] irq_n_in,
  output logic [N_CH-1:0] irq_sync,
  output logic            irq_n_out
);
  logic [N_CH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '1;
      irq_sync <= '1;
    end else begin
      stage1   <= irq_n_in;
      irq_sync <= stage1;
    end
  end

  assign irq_n_out = &irq_n_in;
endmodule

// File: rtl/i2c_chansel_engine.sv
module i2c_chansel_engine
  import i2c_chansel_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic [2:0] addr_pins,
  input  logic [3:0] irq_sync,
  output logic [2:0] sel_q,
  output logic       sda_pull
);
  xfer_st_e   st;
  logic [2:0] bit_cnt;
  logic [7:0] sh;
  logic       rw, ack_phase, m_ack, pend_vld;
  logic [2:0] pend;
  logic [7:0] rd_byte;

  assign rd_byte = status_byte(irq_sync, sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bit_cnt <= '0; sh <= '0; rw <= 1'b0;
      ack_phase <= 1'b0; m_ack <= 1'b0; pend_vld <= 1'b0;
      pend <= '0; sel_q <= '0; sda_pull <= 1'b0;
    end else if (start_evt) begin
      st <= ST_ADDR; bit_cnt <= '0; sda_pull <= 1'b0;
      ack_phase <= 1'b0; pend_vld <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE; sda_pull <= 1'b0; ack_phase <= 1'b0;
      if (pend_vld) sel_q <= pend;
      pend_vld <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: if (scl_rise) begin
          sh <= {sh[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rw <= sda_lvl;
            st <= addr_match(sh[6:0], ADDR_HI, addr_pins) ? ST_AACK : ST_SKIP;
          end
        end
        ST_AACK, ST_WACK: if (scl_fall) begin
          if (!ack_phase) begin
            sda_pull <= 1'b1; ack_phase <= 1'b1;
          end else begin
            ack_phase <= 1'b0; bit_cnt <= '0;
            if (st == ST_AACK && rw) begin
              sh <= rd_byte; sda_pull <= ~rd_byte[7]; st <= ST_RDATA;
            end else begin
              sda_pull <= 1'b0; st <= ST_WDATA;
            end
          end
        end
        ST_WDATA: if (scl_rise) begin
          sh <= {sh[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            pend <= {sh[1:0], sda_lvl}; pend_vld <= 1'b1; st <= ST_WACK;
          end
        end
        ST_RDATA: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            sda_pull <= 1'b0; st <= ST_RACK;
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_pull <= ~sh[6];
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) m_ack <= ~sda_lvl;
          else if (scl_fall) begin
            if (m_ack) begin
              sh <= rd_byte; sda_pull <= ~rd_byte[7];
              bit_cnt <= '0; st <= ST_RDATA;
            end else st <= ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_chansel.sv
module i2c_chansel
  import i2c_chansel_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b1110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [2:0] addr_pins,
  input  logic [3:0] irq_n_in,
  output logic       irq_n_out,
  output logic [3:0] chan_en
);
  logic       sda_lvl, start_evt, stop_evt, scl_rise, scl_fall;
  logic [3:0] irq_sync;
  logic [2:0] sel_q;

  i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_irq_gather #(.N_CH(4)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_n_in(irq_n_in),
    .irq_sync(irq_sync), .irq_n_out(irq_n_out)
  );

  i2c_chansel_engine #(.ADDR_HI(ADDR_HI)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .addr_pins(addr_pins), .irq_sync(irq_sync), .sel_q(sel_q),
    .sda_pull(sda_pull)
  );

  assign chan_en = sel_decode(sel_q);
endmodule

// File: rtl/i2c_chansel_checker.sv
module i2c_chansel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       scl_fall,
  input logic       sda_pull,
  input logic [3:0] chan_en,
  input logic [3:0] irq_n_in,
  input logic       irq_n_out
);
  a_r5_onehot_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en));

  a_r4_change_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> $past(stop_evt));

  a_r2_pull_moves_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_evt || stop_evt));

  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull);

  a_r6_any_low_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq_n_in) < 4) |-> !irq_n_out);
endmodule

bind i2c_chansel i2c_chansel_checker u_chk (.*);

// File: tb/i2c_chansel_bench.sv
module i2c_chansel_bench;
  localparam int H = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] irq_n = 4'hF;
  logic sda_pull, irq_n_out;
  logic [3:0] chan_en;
  wire  bus_sda = sda_m & ~sda_pull;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] AW = {4'b1110, PINS, 1'b0};
  localparam logic [7:0] AR = {4'b1110, PINS, 1'b1};
  localparam logic [7:0] AX = {4'b1110, 3'b100, 1'b0};

  always #4 clk = ~clk;

  i2c_chansel u_i2c_chansel (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(bus_sda),
    .sda_pull(sda_pull), .addr_pins(PINS), .irq_n_in(irq_n),
    .irq_n_out(irq_n_out), .chan_en(chan_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw; repeat (H) @(negedge clk); endtask
  task automatic start_c; sda_m = 1; hw; scl_m = 1; hw; sda_m = 0; hw; scl_m = 0; hw; endtask
  task automatic stop_c; sda_m = 0; hw; scl_m = 1; hw; sda_m = 1; hw; endtask
  task automatic put_bit(input logic b); sda_m = b; hw; scl_m = 1; hw; scl_m = 0; hw; endtask
  task automatic get_bit(output logic b); sda_m = 1; hw; scl_m = 1; hw; b = bus_sda; scl_m = 0; hw; endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x); ack = ~x;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~mack);
  endtask

  task automatic t_reset;
    check("R1 chan_en", {4'h0, chan_en}, 8'h00);
    check("R1 sda_pull", {7'h0, sda_pull}, 8'h00);
    check("R6 idle irq", {7'h0, irq_n_out}, 8'h01);
  endtask

  task automatic t_write_apply;
    logic a;
    start_c; send_byte(AW, a); check("R2 addr ack", {7'h0, a}, 8'h01);
    send_byte(8'h05, a); check("R3 data ack", {7'h0, a}, 8'h01);
    check("R4 held before STOP", {4'h0, chan_en}, 8'h00);
    stop_c; hw;
    check("R4 R5 applied ch1", {4'h0, chan_en}, 8'h02);
  endtask

  task automatic t_multi;
    logic a;
    start_c; send_byte(AW, a); send_byte(8'h04, a); send_byte(8'h07, a);
    check("R3 last byte ack", {7'h0, a}, 8'h01);
    stop_c; hw;
    check("R3 last byte wins", {4'h0, chan_en}, 8'h08);
  endtask

  task automatic t_disable;
    logic a;
    start_c; send_byte(AW, a); send_byte(8'h03, a); stop_c; hw;
    check("R5 bit2 clear", {4'h0, chan_en}, 8'h00);
    start_c; send_byte(AW, a); send_byte(8'h06, a); stop_c; hw;
    check("R5 ch2", {4'h0, chan_en}, 8'h04);
  endtask

  task automatic t_mismatch;
    logic a;
    start_c; send_byte(AX, a); check("R10 no ack", {7'h0, a}, 8'h00);
    send_byte(8'h05, a); stop_c; hw;
    check("R10 selection kept", {4'h0, chan_en}, 8'h04);
  endtask

  task automatic t_read;
    logic a, x; logic [7:0] b;
    irq_n = 4'b0110; hw;
    check("R6 unselected irq seen", {7'h0, irq_n_out}, 8'h00);
    start_c; send_byte(AR, a); check("R2 read ack", {7'h0, a}, 8'h01);
    recv_byte(1'b1, b); check("R7 status byte", b, 8'h96);
    recv_byte(1'b0, b); check("R8 byte after ack", b, 8'h96);
    for (int i = 0; i < 3; i++) begin
      get_bit(x); check("R8 released after nack", {7'h0, x}, 8'h01);
    end
    stop_c;
    irq_n = 4'hF; hw;
    check("R6 irq cleared", {7'h0, irq_n_out}, 8'h01);
  endtask

  task automatic t_drop;
    logic a;
    start_c; send_byte(AW, a); send_byte(8'h05, a);
    start_c; send_byte(AX, a); stop_c; hw;
    check("R9 pending dropped", {4'h0, chan_en}, 8'h04);
  endtask

  task automatic t_midbyte;
    logic a;
    start_c; put_bit(1); put_bit(1); put_bit(1);
    start_c; send_byte(AW, a); check("R9 restart ack", {7'h0, a}, 8'h01);
    send_byte(8'h04, a); stop_c; hw;
    check("R9 restart write", {4'h0, chan_en}, 8'h01);
  endtask

  task automatic t_same_cycle;
    logic a; logic [7:0] b;
    start_c; send_byte(AW, a); send_byte(8'h07, a);
    sda_m = 0; hw; scl_m = 1; hw; sda_m = 1; irq_n = 4'b1101; hw;
    check("R4 STOP with irq edge", {4'h0, chan_en}, 8'h08);
    check("R6 irq with STOP", {7'h0, irq_n_out}, 8'h00);
    start_c; send_byte(AR, a); recv_byte(1'b0, b); stop_c;
    check("R7 status after switch", b, 8'h27);
    irq_n = 4'hF; hw;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hw;
    t_reset; t_write_apply; t_multi; t_disable; t_mismatch;
    t_read; t_drop; t_midbyte; t_same_cycle;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule